// File: doc/BRIEF.md
# Two-Wire Serial Clock Rate Generator

This block produces the serial clock of a two-wire bus master from the system clock. Software supplies an 8-bit rate value and a 2-bit prescaler code. The clock period, counted in system-clock cycles, is sixteen plus twice the rate value times the prescaler multiplier. The line is open-drain, so the block only pulls SCL low or lets it go. It reads the real line level back through a synchroniser. The released half of the period is not counted until the line is actually seen high. A slave that holds the clock low therefore stretches the period by exactly the time it holds the line.

The generator is a four-state machine. `ST_IDLE` is the disabled state. `ST_LOW` pulls the line low and counts the low half. `ST_WAIT_HI` releases the line and waits for the synchronised level to read high. `ST_HIGH` counts the rest of the released half. The transitions are:
- IDLE→LOW when enabled.
- LOW→WAIT_HI at the last low cycle.
- WAIT_HI→HIGH when the synchronised line reads high.
- HIGH→LOW at the last high cycle.
- Any state→IDLE when the enable drops.

Phase lengths are latched on every entry to `ST_LOW`. Two one-cycle strobes mark the first low cycle, where SDA may change, and the first counted high cycle, where SDA may be sampled.

Top module: `scl_rate_gen`

## Requirements
- R1: With the line following the drive at once, one full period (pulled cycles plus released cycles) lasts 16 + 2·rate·M system clocks. M is 1, 4, 16 or 64 for prescaler codes 0, 1, 2 and 3.
- R2: The pulled interval lasts ceil(D/2) cycles and the released interval lasts floor(D/2) cycles, where D is the period of R1.
- R3: Each cycle that a slave holds the line low after release adds exactly one cycle to the released interval. The pulled interval does not change.
- R4: The line level passes through a two-flop synchroniser. `sda_sample_stb` pulses for one cycle in the fourth released cycle when the line rises at once. Each cycle of stretching delays it by one cycle, and it only occurs while the line is released.
- R5: `sda_drive_stb` pulses for exactly one cycle, in the first pulled cycle of every low phase. It never coincides with `sda_sample_stb`.
- R6: A new rate or prescaler value written during a phase leaves the current period unchanged. It applies from the next low phase onward.
- R7: When `en` is low, the line is released and both strobes are zero from the next cycle on. When `en` returns high, the next cycle starts a full-length low phase with `sda_drive_stb` high.
- R8: During reset the line is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| bit_rate | input | 8 | Rate value in the period formula |
| pre_sel | input | 2 | Prescaler code: multiplier 1, 4, 16, 64 |
| scl_in | input | 1 | Sampled SCL line level (asynchronous) |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |
| sda_drive_stb | output | 1 | One-cycle pulse in the first pulled cycle |
| sda_sample_stb | output | 1 | One-cycle pulse in the first counted high cycle |

## Verification
`scl_pull` and both strobes are decoded from registered state. Each therefore changes in the cycle directly after the edge that moves the machine. Release is seen in the next cycle. The sample strobe follows three cycles later, two for the synchroniser and one for the state update, plus any stretch cycles. An enable change shows at the outputs one cycle after it is applied. The bench drives inputs and samples outputs on falling edges and measures each interval by counting those falling edges. Every expected length and strobe position is therefore an exact cycle count taken from R1–R7.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_HIGH    = 2'd3
    } scl_state_e;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/scl_divisor.sv
module scl_divisor #(
    parameter int RATE_W   = 8,
    parameter int SEL_W    = 2,
    parameter int MIN_DIV  = 16,
    parameter int SYNC_LAT = 3,
    parameter int CNT_W    = 16
) (
    input  logic [RATE_W-1:0] rate,
    input  logic [SEL_W-1:0]  sel,
    output logic [CNT_W-1:0]  low_len,
    output logic [CNT_W-1:0]  high_len
);
    localparam int PROD_W = RATE_W + 2 * ((1 << SEL_W) - 1);

    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  div;
    logic [CNT_W:0]    div_up;

    always_comb begin
        // multiplier is 4**sel: shift by twice the code
        prod     = PROD_W'(rate) << {sel, 1'b0};
        div      = CNT_W'(MIN_DIV) + (CNT_W'(prod) << 1);
        div_up   = {1'b0, div} + 1'b1;
        low_len  = div_up[CNT_W:1];
        // released half includes the fixed wait for the synchronised level
        high_len = (div >> 1) - CNT_W'(SYNC_LAT);
    end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rate_pkg::*;
#(
    parameter int RATE_W      = 8,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_DIV     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] bit_rate,
    input  logic [SEL_W-1:0]  pre_sel,
    input  logic              scl_in,
    output logic              scl_pull,
    output logic              sda_drive_stb,
    output logic              sda_sample_stb
);
    localparam int SYNC_LAT = SYNC_STAGES + 1;
    localparam int PROD_W   = RATE_W + 2 * ((1 << SEL_W) - 1);
    localparam int CNT_W    = PROD_W + 2;

    scl_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] low_q, high_q;
    logic [CNT_W-1:0] low_d, high_d;
    logic             scl_hi;

    scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (scl_in),
        .dout  (scl_hi)
    );

    scl_divisor #(
        .RATE_W   (RATE_W),
        .SEL_W    (SEL_W),
        .MIN_DIV  (MIN_DIV),
        .SYNC_LAT (SYNC_LAT),
        .CNT_W    (CNT_W)
    ) u_div (
        .rate     (bit_rate),
        .sel      (pre_sel),
        .low_len  (low_d),
        .high_len (high_d)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (en) nxt = ST_LOW;
            ST_LOW:     if (cnt == low_q - 1'b1) nxt = ST_WAIT_HI;
            ST_WAIT_HI: if (scl_hi) nxt = ST_HIGH;
            ST_HIGH:    if (cnt == high_q - 1'b1) nxt = ST_LOW;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || state == ST_IDLE || state == ST_WAIT_HI)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            // new rate settings are taken only when a low phase begins
            if (nxt == ST_LOW && state != ST_LOW) begin
                low_q  <= low_d;
                high_q <= high_d;
            end
        end
    end

    always_comb begin
        scl_pull       = (state == ST_LOW);
        sda_drive_stb  = (state == ST_LOW)  && (cnt == '0);
        sda_sample_stb = (state == ST_HIGH) && (cnt == '0);
    end
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_pull,
    input logic sda_drive_stb,
    input logic sda_sample_stb
);
    p_drive_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_stb |-> scl_pull);

    p_drive_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> sda_drive_stb);

    p_strobe_mutex_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_drive_stb && sda_sample_stb));

    p_sample_seen_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample_stb |-> (!scl_pull && $past(scl_in, 3)));

    p_off_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull && !sda_drive_stb && !sda_sample_stb));

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r8: assert (!sda_drive_stb && !sda_sample_stb);
        end
    end
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .scl_in         (scl_in),
    .scl_pull       (scl_pull),
    .sda_drive_stb  (sda_drive_stb),
    .sda_sample_stb (sda_sample_stb)
);

// File: tb/scl_rate_gen_test.sv
module scl_rate_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] rate = 8'd0;
    logic [1:0] sel = 2'd0;
    logic       hold = 1'b0;
    logic       scl_line;
    logic       scl_pull, sda_drive_stb, sda_sample_stb;
    int         nchk = 0, nfail = 0, cyc = 0;
    bit         done = 1'b0;

    // open-drain line with an ideal pull-up; hold models a stretching slave
    assign scl_line = ~scl_pull & ~hold;

    scl_rate_gen uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .bit_rate       (rate),
        .pre_sel        (sel),
        .scl_in         (scl_line),
        .scl_pull       (scl_pull),
        .sda_drive_stb  (sda_drive_stb),
        .sda_sample_stb (sda_sample_stb)
    );

    always #2 clk = ~clk;

    // {rate, prescaler code, expected period}
    localparam logic [25:0] VEC [8] = '{
        {8'd0,   2'd0, 16'd16},
        {8'd1,   2'd0, 16'd18},
        {8'd2,   2'd1, 16'd32},
        {8'd5,   2'd1, 16'd56},
        {8'd3,   2'd2, 16'd112},
        {8'd1,   2'd3, 16'd144},
        {8'd100, 2'd0, 16'd216},
        {8'd255, 2'd0, 16'd526}
    };

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_period(input int stretch, input bit at_rise, input bit chg,
                              input logic [7:0] nr, input logic [1:0] ns,
                              output int lo, output int hi, output int spos,
                              output bit dstb, output bit dstb2);
        bit prev;
        if (!at_rise) begin
            prev = 1'b1;
            forever begin
                @(negedge clk);
                if (scl_pull && !prev) break;
                prev = scl_pull;
            end
        end
        dstb = sda_drive_stb;
        if (chg) begin rate = nr; sel = ns; end
        lo = 1; dstb2 = 1'b0;
        forever begin
            @(negedge clk);
            if (!scl_pull) break;
            lo++;
            if (lo == 2) dstb2 = sda_drive_stb;
        end
        hi = 1; spos = 0;
        if (stretch > 0) hold = 1'b1;
        forever begin
            if (hi == stretch + 1) hold = 1'b0;
            @(negedge clk);
            if (scl_pull) break;
            hi++;
            if (sda_sample_stb && spos == 0) spos = hi;
        end
    endtask

    initial begin
        int  lo, hi, sp;
        bit  d1, d2;
        repeat (3) @(negedge clk);
        check("R8 reset pull", int'(scl_pull), 0);
        check("R8 reset drive strobe", int'(sda_drive_stb), 0);
        check("R8 reset sample strobe", int'(sda_sample_stb), 0);
        rst_n = 1'b1; en = 1'b1;

        for (int i = 0; i < 8; i++) begin
            int d;
            rate = VEC[i][25:18]; sel = VEC[i][17:16]; d = int'(VEC[i][15:0]);
            run_period(0, 1'b0, 1'b0, 8'd0, 2'd0, lo, hi, sp, d1, d2);
            check("R1 period", lo + hi, d);
            check("R2 low half", lo, (d + 1) / 2);
            check("R2 high half", hi, d / 2);
            check("R4 sample strobe position", sp, 4);
            check("R5 drive strobe first cycle", int'(d1), 1);
            check("R5 drive strobe single cycle", int'(d2), 0);
        end

        // R3: stretching lengthens only the released half
        rate = 8'd2; sel = 2'd1;
        run_period(5, 1'b0, 1'b0, 8'd0, 2'd0, lo, hi, sp, d1, d2);
        check("R3 low unchanged", lo, 16);
        check("R3 stretched high", hi, 21);
        check("R4 stretched sample pos", sp, 9);
        rate = 8'd3; sel = 2'd2;
        run_period(1, 1'b0, 1'b0, 8'd0, 2'd0, lo, hi, sp, d1, d2);
        check("R3 one-cycle stretch", hi, 57);
        check("R4 one-cycle stretch sample", sp, 5);

        // R6: change inside a low phase, then next period
        rate = 8'd2; sel = 2'd1;
        run_period(0, 1'b0, 1'b1, 8'd0, 2'd0, lo, hi, sp, d1, d2);
        check("R6 current low keeps old", lo, 16);
        check("R6 current high keeps old", hi, 16);
        run_period(0, 1'b1, 1'b0, 8'd0, 2'd0, lo, hi, sp, d1, d2);
        check("R6 next low new", lo, 8);
        check("R6 next high new", hi, 8);

        // R1 largest divisor
        rate = 8'd255; sel = 2'd3;
        run_period(0, 1'b0, 1'b0, 8'd0, 2'd0, lo, hi, sp, d1, d2);
        check("R1 max period", lo + hi, 32656);

        // R7: disable in the middle of a low phase
        rate = 8'd0; sel = 2'd0;
        run_period(0, 1'b0, 1'b0, 8'd0, 2'd0, lo, hi, sp, d1, d2);
        @(negedge clk); en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R7 disabled pull", int'(scl_pull), 0);
            check("R7 disabled strobes", int'(sda_drive_stb | sda_sample_stb), 0);
        end
        en = 1'b1;
        @(negedge clk);
        check("R7 re-enable pull", int'(scl_pull), 1);
        run_period(0, 1'b1, 1'b0, 8'd0, 2'd0, lo, hi, sp, d1, d2);
        check("R7 re-enable drive strobe", int'(d1), 1);
        check("R7 re-enable full low", lo, 8);
        check("R7 re-enable high", hi, 8);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            nchk++; nfail++;
            $display("FAIL R1 watchdog: actual=%0d cycles expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule